// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block receives one memory-fetch request from a group of lanes and splits it into the smallest practical set of downstream memory transactions. Each lane supplies an active bit and the byte address of a 4-byte word. The block sorts the active lanes by the aligned 128-byte line they fall into. For each line it finds which 32-byte sectors are touched and issues one transaction covering one, two or four sectors. The transaction carries the line address, the sector mask and the mask of the lanes it serves.

Both sides use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. After that `req_ready` stays low until the last transaction of the request has been handed off. Transactions come out one per cycle in ascending line order. While `txn_ready` is low, the current transaction stays on the output with its fields unchanged. It is replaced only after a cycle in which `txn_valid` and `txn_ready` are both high.

When a request finishes, a plain status pulse reports three counts: transactions issued, bytes actually used by the lanes, and bytes fetched. Software can use these to judge how well the request was coalesced.

Top module: `coal_warp_coalescer`

## Requirements
- R1: Out of reset `req_ready` is 1 and `txn_valid` and `stat_valid` are 0. A request is accepted when `req_valid` and `req_ready` are both high. Once a request with at least one active lane has been accepted, `req_ready` is 0 until its last transaction has been handed off.
- R2: A lane whose `req_active` bit is 0 adds nothing to any transaction or count. A request with no active lanes issues no transaction. One cycle after it is accepted, such a request produces a `stat_valid` pulse with all counts 0.
- R3: The line of a lane is address bits [ADDR_W-1:7]. All active lanes in the same line are served by exactly one transaction, whatever the order of the lanes. In `txn_lanes`, bit i set means lane i is served by that transaction.
- R4: The sector of a lane is address bits [6:5]. Bit k of `txn_sectors` stands for sector k. Let S be the set of touched sectors of a line.
  - If S holds one sector, only that bit is set.
  - Otherwise, if S lies within sectors 0–1, the mask is 0011; if it lies within sectors 2–3, the mask is 1100.
  - Otherwise the mask is 1111.
- R5: The lines of a request are issued in strictly ascending line address order, on `txn_line`. One transaction is handed off on each cycle in which `txn_valid` and `txn_ready` are both high.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, on the next cycle `txn_valid` is still 1 and `txn_line`, `txn_sectors` and `txn_lanes` are unchanged.
- R7: When active lanes are spaced 128 bytes apart, each lane gets its own transaction. Sixteen such lanes give 16 transactions, 512 fetched bytes and 64 used bytes.
- R8: `stat_used_bytes` equals 4 times the number of distinct word addresses (address bits [ADDR_W-1:2]) among the active lanes. Address bits [1:0] are ignored.
- R9: `stat_valid` pulses for one cycle, in the cycle after the final handoff. At that pulse, `stat_txns` is the number of transactions handed off and `stat_fetched_bytes` is 32 times the total number of sector bits set across them.
- R10: The extra sector from a misaligned shift is counted.
  - Sixteen consecutive words starting at line offset 4 give one transaction with mask 1111 and 128 fetched bytes.
  - Starting at offset 96, they give two transactions, masks 1000 and 0001, and 64 fetched bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | ADDR_W-7 | Line address of the transaction |
| txn_sectors | output | 4 | Sectors fetched within the line |
| txn_lanes | output | LANES | Lanes served by the transaction |
| stat_valid | output | 1 | One-cycle pulse when a request completes |
| stat_txns | output | $clog2(LANES+1) | Transactions issued for the request |
| stat_used_bytes | output | $clog2(4*LANES+1) | Bytes the lanes actually need |
| stat_fetched_bytes | output | $clog2(128*LANES+1) | Bytes fetched by the transactions |

## Verification
The bench builds the block with its defaults: 16 lanes, 32-bit addresses, 128-byte lines and 32-byte sectors. That gives four sectors per line, so every span size (one, two and four sectors) and every aligned placement can be reached. Sixteen lanes can spread across as many as sixteen lines, so a request can need the full count of transactions. Lanes can also straddle a line boundary, and duplicate words can shrink the used-byte count. Random back-pressure on `txn_ready` exercises the hold rule with these defaults.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_t;
endpackage

// File: rtl/coal_line_pick.sv
// Finds the lowest line among pending lanes, the lanes in it and their raw sector set.
module coal_line_pick #(
  parameter int LANES        = 16,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] line_min,
  output logic [LANES-1:0]        lanes,
  output logic [LINE_BYTES/SECTOR_BYTES-1:0] sect_raw
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int SEC_SH  = $clog2(SECTOR_BYTES);
  localparam int SECTORS = LINE_BYTES / SECTOR_BYTES;
  localparam int SEC_W   = $clog2(SECTORS);
  localparam int LINE_W  = ADDR_W - OFF_W;

  logic [LINE_W-1:0] lane_line [LANES];
  logic [SEC_W-1:0]  lane_sec  [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_line[g] = addr_flat[g*ADDR_W+OFF_W +: LINE_W];
    assign lane_sec[g]  = addr_flat[g*ADDR_W+SEC_SH +: SEC_W];
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    line_min = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || lane_line[i] < line_min)) begin
        line_min = lane_line[i];
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    lanes    = '0;
    sect_raw = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && lane_line[i] == line_min) begin
        lanes[i]              = 1'b1;
        sect_raw[lane_sec[i]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_sector_span.sv
// Rounds a touched-sector set up to the smallest aligned power-of-two span.
module coal_sector_span #(
  parameter int SECTORS = 4
) (
  input  logic [SECTORS-1:0] raw,
  output logic [SECTORS-1:0] span
);
  localparam int LVLS = $clog2(SECTORS);
  localparam int W2   = 2 * SECTORS;

  always_comb begin
    logic [W2-1:0]      ones;
    logic [W2-1:0]      shifted;
    logic [SECTORS-1:0] blk;
    span = '1;
    for (int lv = LVLS; lv >= 0; lv--) begin
      ones = (W2'(1) << (1 << lv)) - W2'(1);
      for (int b = 0; b < SECTORS; b++) begin
        if ((b << lv) < SECTORS) begin
          shifted = ones << (b << lv);
          blk     = shifted[SECTORS-1:0];
          if ((raw & ~blk) == '0) span = blk;
        end
      end
    end
  end
endmodule

// File: rtl/coal_unique_count.sv
// Counts active lanes whose word address is not shared with a lower active lane.
module coal_unique_count #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 5
) (
  input  logic [LANES-1:0]        act,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [CNT_W-1:0]        count
);
  localparam int WSH = $clog2(WORD_BYTES);
  localparam int WW  = ADDR_W - WSH;

  logic [WW-1:0] word [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_word
    assign word[g] = addr_flat[g*ADDR_W+WSH +: WW];
  end

  always_comb begin
    logic dup;
    count = '0;
    for (int i = 0; i < LANES; i++) begin
      dup = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (act[j] && word[j] == word[i]) dup = 1'b1;
      end
      if (act[i] && !dup) count = count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/coal_warp_coalescer.sv
module coal_warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic [LANES-1:0]                        req_active,
  input  logic [LANES*ADDR_W-1:0]                 req_addr,
  output logic                                    txn_valid,
  input  logic                                    txn_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    txn_line,
  output logic [LINE_BYTES/SECTOR_BYTES-1:0]      txn_sectors,
  output logic [LANES-1:0]                        txn_lanes,
  output logic                                    stat_valid,
  output logic [$clog2(LANES+1)-1:0]              stat_txns,
  output logic [$clog2(LANES*WORD_BYTES+1)-1:0]   stat_used_bytes,
  output logic [$clog2(LANES*LINE_BYTES+1)-1:0]   stat_fetched_bytes
);
  localparam int SECTORS = LINE_BYTES / SECTOR_BYTES;
  localparam int TXN_W   = $clog2(LANES + 1);
  localparam int USED_W  = $clog2(LANES * WORD_BYTES + 1);
  localparam int FETCH_W = $clog2(LANES * LINE_BYTES + 1);
  localparam int UCNT_W  = $clog2(LANES + 1);

  coal_state_t             state_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [USED_W-1:0]       used_q;
  logic [FETCH_W-1:0]      fetch_acc_q;
  logic [TXN_W-1:0]        txn_acc_q;

  logic [SECTORS-1:0]      sect_raw;
  logic [UCNT_W-1:0]       uniq_cnt;
  logic                    req_hs;
  logic                    txn_hs;
  logic [LANES-1:0]        pend_next;
  logic [FETCH_W-1:0]      fetch_add;

  coal_line_pick #(
    .LANES(LANES), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_pick (
    .pend(pend_q), .addr_flat(addr_q),
    .line_min(txn_line), .lanes(txn_lanes), .sect_raw(sect_raw)
  );

  coal_sector_span #(.SECTORS(SECTORS)) u_span (
    .raw(sect_raw), .span(txn_sectors)
  );

  coal_unique_count #(
    .LANES(LANES), .ADDR_W(ADDR_W),
    .WORD_BYTES(WORD_BYTES), .CNT_W(UCNT_W)
  ) u_uniq (
    .act(req_active), .addr_flat(req_addr), .count(uniq_cnt)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign txn_valid = (state_q == ST_BUSY);
  assign req_hs    = req_valid && req_ready;
  assign txn_hs    = txn_valid && txn_ready;
  assign pend_next = pend_q & ~txn_lanes;
  assign fetch_add = FETCH_W'(SECTOR_BYTES) * FETCH_W'($countones(txn_sectors));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q            <= ST_IDLE;
      pend_q             <= '0;
      addr_q             <= '0;
      used_q             <= '0;
      fetch_acc_q        <= '0;
      txn_acc_q          <= '0;
      stat_valid         <= 1'b0;
      stat_txns          <= '0;
      stat_used_bytes    <= '0;
      stat_fetched_bytes <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (req_hs) begin
        addr_q      <= req_addr;
        pend_q      <= req_active;
        used_q      <= USED_W'(uniq_cnt) * USED_W'(WORD_BYTES);
        fetch_acc_q <= '0;
        txn_acc_q   <= '0;
        if (req_active == '0) begin
          stat_valid         <= 1'b1;
          stat_txns          <= '0;
          stat_used_bytes    <= '0;
          stat_fetched_bytes <= '0;
        end else begin
          state_q <= ST_BUSY;
        end
      end else if (txn_hs) begin
        pend_q      <= pend_next;
        fetch_acc_q <= fetch_acc_q + fetch_add;
        txn_acc_q   <= txn_acc_q + TXN_W'(1);
        if (pend_next == '0) begin
          state_q            <= ST_IDLE;
          stat_valid         <= 1'b1;
          stat_txns          <= txn_acc_q + TXN_W'(1);
          stat_used_bytes    <= used_q;
          stat_fetched_bytes <= fetch_acc_q + fetch_add;
        end
      end
    end
  end
endmodule

// File: rtl/coal_checks.sv
module coal_checks #(
  parameter int LANES        = 16,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  req_valid,
  input logic                                  req_ready,
  input logic [LANES-1:0]                      req_active,
  input logic                                  txn_valid,
  input logic                                  txn_ready,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  txn_line,
  input logic [LINE_BYTES/SECTOR_BYTES-1:0]    txn_sectors,
  input logic [LANES-1:0]                      txn_lanes,
  input logic                                  stat_valid,
  input logic [$clog2(LANES+1)-1:0]            stat_txns,
  input logic [$clog2(LANES*LINE_BYTES+1)-1:0] stat_fetched_bytes
);
  localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES);

  logic              have_prev;
  logic [LINE_W-1:0] prev_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_line <= '0;
    end else if (req_valid && req_ready) begin
      have_prev <= 1'b0;
    end else if (txn_valid && txn_ready) begin
      have_prev <= 1'b1;
      prev_line <= txn_line;
    end
  end

  a_r1_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && txn_valid));

  a_r2_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_active == '0) |=> (!txn_valid && stat_valid && stat_txns == '0));

  a_r3_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes != '0));

  a_r4_legal_span: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_sectors inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                       4'b0011, 4'b1100, 4'b1111}));

  a_r5_ascending_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && have_prev) |-> (txn_line > prev_line));

  a_r6_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) &&
                                   $stable(txn_sectors) && $stable(txn_lanes)));

  a_r9_fetch_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (int'(stat_fetched_bytes) >= int'(stat_txns) * SECTOR_BYTES &&
                    int'(stat_fetched_bytes) <= int'(stat_txns) * LINE_BYTES));
endmodule

bind coal_warp_coalescer coal_checks #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .SECTOR_BYTES(SECTOR_BYTES), .WORD_BYTES(WORD_BYTES)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_active(req_active), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_line(txn_line), .txn_sectors(txn_sectors), .txn_lanes(txn_lanes),
  .stat_valid(stat_valid), .stat_txns(stat_txns),
  .stat_fetched_bytes(stat_fetched_bytes)
);

// File: tb/sim_coal_warp_coalescer.sv
`timescale 1ns/1ps
module sim_coal_warp_coalescer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [15:0]  req_active;
  logic [511:0] req_addr;
  logic         txn_valid;
  logic         txn_ready;
  logic [24:0]  txn_line;
  logic [3:0]   txn_sectors;
  logic [15:0]  txn_lanes;
  logic         stat_valid;
  logic [4:0]   stat_txns;
  logic [6:0]   stat_used_bytes;
  logic [11:0]  stat_fetched_bytes;

  coal_warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_line(txn_line), .txn_sectors(txn_sectors),
    .txn_lanes(txn_lanes), .stat_valid(stat_valid), .stat_txns(stat_txns),
    .stat_used_bytes(stat_used_bytes), .stat_fetched_bytes(stat_fetched_bytes)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  bit [31:0] ta [16];
  bit [15:0] tact;
  bit [24:0] e_line [16];
  bit [3:0]  e_sec  [16];
  bit [15:0] e_lan  [16];
  int        e_n, e_fetch, e_used;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic model();
    bit [15:0] pend;
    bit [24:0] ml;
    bit [3:0]  sm;
    bit [15:0] lm;
    bit        found, dup;
    int        lo, hi;
    e_n = 0; e_fetch = 0; e_used = 0;
    for (int i = 0; i < 16; i++) begin
      dup = 0;
      for (int j = 0; j < i; j++)
        if (tact[j] && ta[j][31:2] == ta[i][31:2]) dup = 1;
      if (tact[i] && !dup) e_used += 4;
    end
    pend = tact;
    while (pend != 0) begin
      found = 0; ml = 0;
      for (int i = 0; i < 16; i++)
        if (pend[i] && (!found || ta[i][31:7] < ml)) begin ml = ta[i][31:7]; found = 1; end
      lm = 0; sm = 0;
      for (int i = 0; i < 16; i++)
        if (pend[i] && ta[i][31:7] == ml) begin lm[i] = 1; sm[ta[i][6:5]] = 1; end
      lo = -1; hi = 0;
      for (int s = 0; s < 4; s++)
        if (sm[s]) begin if (lo < 0) lo = s; hi = s; end
      if (lo == hi)     sm = 4'(1 << lo);
      else if (hi <= 1) sm = 4'b0011;
      else if (lo >= 2) sm = 4'b1100;
      else              sm = 4'b1111;
      e_line[e_n] = ml; e_sec[e_n] = sm; e_lan[e_n] = lm;
      e_fetch += 32 * $countones(sm);
      e_n++;
      pend &= ~lm;
    end
  endtask

  // Called at a falling edge with the block idle.
  task automatic run_req(input int stall_pct);
    int        k, guard;
    bit        held, rdy;
    bit [24:0] h_line;
    bit [3:0]  h_sec;
    bit [15:0] h_lan;
    model();
    for (int i = 0; i < 16; i++) req_addr[i*32 +: 32] = ta[i];
    req_active = tact;
    req_valid  = 1'b1;
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (tact != 0) chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
    k = 0; guard = 0; held = 0;
    while (!stat_valid && guard < 400) begin
      if (held) begin
        chk(txn_valid && txn_line == h_line && txn_sectors == h_sec && txn_lanes == h_lan,
            "R6 held transaction", {txn_line, txn_sectors, txn_lanes}, {h_line, h_sec, h_lan});
        held = 0;
      end
      if (txn_valid) begin
        rdy = ($urandom_range(0, 99) >= stall_pct);
        txn_ready = rdy;
        if (rdy) begin
          if (k < e_n) begin
            chk(txn_line == e_line[k], "R5 line order", 64'(txn_line), 64'(e_line[k]));
            chk(txn_sectors == e_sec[k], "R4 sector span", 64'(txn_sectors), 64'(e_sec[k]));
            chk(txn_lanes == e_lan[k], "R3 lane mask", 64'(txn_lanes), 64'(e_lan[k]));
          end else begin
            chk(1'b0, "R5 extra transaction", 64'(k + 1), 64'(e_n));
          end
          k++;
        end else begin
          held = 1; h_line = txn_line; h_sec = txn_sectors; h_lan = txn_lanes;
        end
      end else begin
        txn_ready = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      guard++;
    end
    txn_ready = 1'b0;
    chk(stat_valid == 1'b1, "R9 completion pulse", 64'(stat_valid), 64'd1);
    chk(k == e_n, "R5 transaction count", 64'(k), 64'(e_n));
    chk(int'(stat_txns) == e_n, "R9 stat_txns", 64'(stat_txns), 64'(e_n));
    chk(int'(stat_fetched_bytes) == e_fetch, "R9 fetched bytes", 64'(stat_fetched_bytes), 64'(e_fetch));
    chk(int'(stat_used_bytes) == e_used, "R8 used bytes", 64'(stat_used_bytes), 64'(e_used));
    @(posedge clk); @(negedge clk);
    chk(stat_valid == 1'b0, "R9 pulse one cycle", 64'(stat_valid), 64'd0);
  endtask

  task automatic fill(input bit [31:0] base, input int stride);
    for (int i = 0; i < 16; i++) ta[i] = base + 32'(i * stride);
  endtask

  initial begin
    int mode;
    bit [31:0] base;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_active = '0; req_addr = '0; txn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0 && stat_valid == 1'b0, "R1 reset state",
        {req_ready, txn_valid, stat_valid}, 64'b100);

    // R2: no active lanes
    fill(32'h0000_5000, 128); tact = 16'h0000;
    run_req(0);
    chk(int'(stat_txns) == 0 && stat_used_bytes == 0, "R2 empty request", 64'(stat_txns), 64'd0);

    // R2: inactive lanes point elsewhere and must not widen anything
    fill(32'h0000_3000, 4);
    for (int i = 8; i < 16; i++) ta[i] = 32'h0009_0000 + 32'(i * 128);
    tact = 16'h00FF;
    run_req(0);
    chk(int'(stat_txns) == 1 && int'(stat_fetched_bytes) == 32, "R2 inactive ignored",
        64'(stat_fetched_bytes), 64'd32);

    // R3: one line, scrambled lane order
    for (int i = 0; i < 16; i++) ta[i] = 32'h0000_1000 + 32'(((i * 5) % 32) * 4);
    tact = 16'hFFFF;
    run_req(30);
    chk(int'(stat_txns) == 1, "R3 one transaction per line", 64'(stat_txns), 64'd1);

    // R7: 128-byte stride
    fill(32'h0000_8000, 128); tact = 16'hFFFF;
    run_req(20);
    chk(int'(stat_txns) == 16 && int'(stat_fetched_bytes) == 512 && int'(stat_used_bytes) == 64,
        "R7 stride 128", {stat_txns, stat_fetched_bytes, stat_used_bytes}, {5'd16, 12'd512, 7'd64});

    // R4: aligned contiguous, two low sectors
    fill(32'h0000_2000, 4); tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_fetched_bytes) == 64, "R4 two-sector span", 64'(stat_fetched_bytes), 64'd64);

    // R10: offset 4 straddles a third sector
    fill(32'h0000_2004, 4); tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_txns) == 1 && int'(stat_fetched_bytes) == 128, "R10 offset 4",
        64'(stat_fetched_bytes), 64'd128);

    // R10: offset 96 crosses into the next line
    fill(32'h0000_2060, 4); tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_txns) == 2 && int'(stat_fetched_bytes) == 64, "R10 offset 96",
        {stat_txns, stat_fetched_bytes}, {5'd2, 12'd64});

    // R8: broadcast with differing low bits
    for (int i = 0; i < 16; i++) ta[i] = 32'h0000_4044 + 32'(i % 4);
    tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_used_bytes) == 4, "R8 broadcast", 64'(stat_used_bytes), 64'd4);

    // R4: sectors 0 and 3 only, then 2 and 3 only
    fill(32'h0000_6000, 4);
    for (int i = 8; i < 16; i++) ta[i] = 32'h0000_6060 + 32'((i - 8) * 4);
    tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_fetched_bytes) == 128, "R4 gap rounds to 1111", 64'(stat_fetched_bytes), 64'd128);
    fill(32'h0000_6040, 4); tact = 16'hFFFF;
    run_req(0);
    chk(int'(stat_fetched_bytes) == 64, "R4 upper pair 1100", 64'(stat_fetched_bytes), 64'd64);

    // Random mix
    for (int r = 0; r < 300; r++) begin
      mode = $urandom_range(0, 5);
      base = 32'h0001_0000 + 32'($urandom_range(0, 1023) * 4);
      case (mode)
        0: fill(base, 4);
        1: fill(base, 8);
        2: fill(base, 128);
        3: fill(base, 0);
        4: for (int i = 0; i < 16; i++) ta[i] = {base[31:7], 7'($urandom_range(0, 127))};
        default: for (int i = 0; i < 16; i++) ta[i] = base + 32'($urandom_range(0, 1023));
      endcase
      tact = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom_range(0, 65535));
      run_req($urandom_range(0, 60));
    end

    summary();
    $finish;
  end
endmodule